// File: doc/BRIEF.md
# Return-Address Shift Stack

This block keeps return addresses for a small processor core. It has a fixed depth of three levels and is built as a chain of registers that shifts, with no memory array and no pointer. A call or an interrupt entry raises the push strobe with the return address. A return or a return-from-interrupt raises the pop strobe. Both kinds of entry and both kinds of return use the stack in exactly the same way.

The top level is always visible on the output, so the core can read the return address in the same cycle that it pops. A push that goes past three levels silently drops the oldest address off the bottom. A pop leaves the bottom level unchanged, so popping more times than entries were pushed keeps returning the deepest surviving address. There are no occupancy, overflow or underflow indications.

Top module: `ret_stack`

## Requirements
- R1: A synchronous reset clears all three levels to zero, so the top output reads 0 and pops made right after reset also return 0.
- R2: The top output follows level 0 combinationally. A pop strobe does not change the top output within the cycle in which it is raised.
- R3: A push alone loads the 9-bit input address into level 0 at the next clock edge, moves old level 0 to level 1, and moves old level 1 to level 2.
- R4: A pop alone moves level 1 into level 0 and level 2 into level 1 at the next clock edge.
- R5: After four pushes in a row, the first pushed address is lost. Pushes of A1, A2, A3, A4 followed by four pops show A4, A3, A2, A2 on the top output.
- R6: A pop leaves level 2 unchanged, so further pops past the pushed depth keep returning the same bottom value.
- R7: When push and pop are raised in the same cycle, the input address replaces level 0 and levels 1 and 2 keep their values.
- R8: With neither strobe raised, all levels hold their values.
- R9: All 9 address bits are stored and returned unaltered, including the all-ones and alternating-bit patterns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push | input | 1 | Push strobe from a call or an interrupt entry |
| pop | input | 1 | Pop strobe from a return or a return-from-interrupt |
| push_addr | input | 9 | Return address to push |
| top_addr | output | 9 | Current top level, which is the address returned by a pop |

## Verification
A fixed sequence of four pushes followed by five pops separates a stack that discards the oldest entry from one that refuses new entries, and it shows whether the bottom value repeats. Pops made right after reset show whether reset cleared the deep levels as well as the top. Cycles that raise push and pop together tell the replace-top rule apart from a push followed by a pop. Long random mixes of push, pop, both and idle are compared cycle by cycle against a queue model, and extreme bit patterns expose dropped or swapped address bits.

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int AW    = 9,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr
);

  localparam int BOT = DEPTH - 1;

  logic [AW-1:0] lvl [DEPTH];
  logic [AW-1:0] nxt [DEPTH];

  always_comb begin
    nxt = lvl;
    if (push)
      nxt[0] = push_addr;
    else if (pop)
      nxt[0] = lvl[1];
    for (int i = 1; i < BOT; i++) begin
      if (push && !pop)
        nxt[i] = lvl[i-1];
      else if (pop && !push)
        nxt[i] = lvl[i+1];
    end
    if (push && !pop)
      nxt[BOT] = lvl[BOT-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) lvl[i] <= '0;
    end else begin
      lvl <= nxt;
    end
  end

  assign top_addr = lvl[0];

  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) === 1'b1 |-> (top_addr == '0 && lvl[BOT] == '0));

  assert_push_loads_top_R3: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> top_addr == $past(push_addr));

  assert_push_shifts_down_R3: assert property (@(posedge clk) disable iff (rst)
    (push && !pop) |=> lvl[1] == $past(top_addr));

  assert_pop_lifts_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> top_addr == $past(lvl[1]));

  assert_pop_keeps_bottom_R6: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> $stable(lvl[BOT]));

  assert_both_replace_top_R7: assert property (@(posedge clk) disable iff (rst)
    (push && pop) |=> (top_addr == $past(push_addr) && $stable(lvl[1]) && $stable(lvl[BOT])));

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!push && !pop) |=> ($stable(top_addr) && $stable(lvl[1]) && $stable(lvl[BOT])));

endmodule

// File: tb/sim_ret_stack.sv
module sim_ret_stack;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic push = 1'b0;
  logic pop = 1'b0;
  logic [8:0] push_addr = '0;
  logic [8:0] top_addr;

  int checks = 0;
  int errors = 0;
  logic [8:0] q[$];
  string last_tag = "R1";

  always #10 clk = ~clk;

  ret_stack u0 (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .push_addr(push_addr), .top_addr(top_addr)
  );

  always @(posedge clk) begin
    if (rst) begin
      q = '{9'd0, 9'd0, 9'd0};
    end else if (push && pop) begin
      q[0] = push_addr;
    end else if (push) begin
      q.push_front(push_addr);
      void'(q.pop_back());
    end else if (pop) begin
      logic [8:0] b;
      b = q[2];
      void'(q.pop_front());
      q.push_back(b);
    end
  end

  task automatic check(input logic [8:0] act, input logic [8:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: top_addr=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input logic p, input logic o, input logic [8:0] d, input string tag);
    push = p; pop = o; push_addr = d;
    #1;
    check(top_addr, q[0], last_tag);
    @(posedge clk);
    @(negedge clk);
    last_tag = tag;
  endtask

  task automatic pop_expect(input logic [8:0] exp, input string tag);
    push = 1'b0; pop = 1'b1; push_addr = 9'h0AA;
    #1;
    check(top_addr, exp, tag);
    @(posedge clk);
    @(negedge clk);
    last_tag = "R4";
  endtask

  task automatic do_reset;
    rst = 1'b1; push = 1'b0; pop = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    last_tag = "R1";
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check(top_addr, 9'd0, "R1 reset top");
    pop_expect(9'd0, "R1 pop after reset");
    pop_expect(9'd0, "R1 second pop after reset");
    pop_expect(9'd0, "R1 third pop after reset");

    do_reset();
    op(1'b1, 1'b0, 9'h101, "R3");
    op(1'b1, 1'b0, 9'h102, "R3");
    op(1'b1, 1'b0, 9'h103, "R3");
    op(1'b1, 1'b0, 9'h104, "R5");
    pop_expect(9'h104, "R5 first pop");
    pop_expect(9'h103, "R5 second pop");
    pop_expect(9'h102, "R5 third pop");
    pop_expect(9'h102, "R5 fourth pop repeats");
    pop_expect(9'h102, "R6 pop past depth");

    do_reset();
    op(1'b1, 1'b0, 9'h1FF, "R9");
    op(1'b1, 1'b0, 9'h155, "R9");
    op(1'b1, 1'b0, 9'h0AA, "R9");
    op(1'b1, 1'b1, 9'h03C, "R7");
    pop_expect(9'h03C, "R7 replaced top");
    pop_expect(9'h155, "R7 level1 kept");
    pop_expect(9'h1FF, "R9 all ones bottom");
    op(1'b0, 1'b0, 9'h000, "R8");
    op(1'b0, 1'b0, 9'h111, "R8");
    check(top_addr, 9'h1FF, "R8 idle hold");

    push = 1'b0; pop = 1'b1; #1;
    check(top_addr, 9'h1FF, "R2 same-cycle top");
    #5;
    check(top_addr, 9'h1FF, "R2 top stable within pop cycle");
    pop = 1'b0;

    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom_range(0, 3);
      case (r)
        0: op(1'b1, 1'b0, 9'($urandom), "R3");
        1: op(1'b0, 1'b1, 9'($urandom), "R4");
        2: op(1'b1, 1'b1, 9'($urandom), "R7");
        default: op(1'b0, 1'b0, 9'($urandom), "R8");
      endcase
    end
    op(1'b0, 1'b0, 9'h000, "R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule